// File: doc/BRIEF.md
# Tri-Level Sync Level Sequencer

This block sits in a video output path. On every pixel clock it chooses which of three analog levels the output should carry: blanking/active video, the sync-pulse tip, or the positive tri-level pulse. Two user-driven sync inputs, one horizontal and one vertical, select the level. The block samples both inputs, finds their edges and moves between levels only on a fixed set of edge combinations. No counters measure line or frame timing. The timing is whatever the user's toggling produces.

The path is active only while a 5-bit input-mode field selects free-running non-standard timing. While the level is blanking/active, the block passes the pixel word through. In the two sync levels it replaces the pixel word with a fixed code. While the path is active, two things are switched off. The first is the embedded timing-code detector, which normally spots the four-word preamble in the pixel stream. The second is the enables for output oversampling and copy-protection processing, which are forced low. With any other mode value, the level is held at blanking and the pixel stream passes through. The detector also runs normally.

Top module: `trilevel_seq`

## Requirements
- R1: After reset the outputs are level_out = 0 (blanking/active), pix_out = 0, sync_err = 0 and tc_hit = 0.
- R2: From blanking (level code 0), a 1→0 edge on hsync while vsync either has a 1→0 edge or stays at 0 moves the level to sync tip (code 1). An input change made before clock edge k shows on level_out after edge k+1.
- R3: From sync tip, a 0→1 edge on vsync while hsync stays at 0 moves the level to tri-level (code 2).
- R4: From tri-level, a 0→1 edge on hsync while vsync stays at 1 moves the level to blanking.
- R5: From sync tip, a 0→1 edge on hsync while vsync stays at 0 moves the level to blanking.
- R6: Some combinations contain a sync edge but are not in R2 to R5. Such a combination leaves the level unchanged and sets sync_err. sync_err stays set until reset.
- R7: pix_out is registered from the level held at the same clock edge. The value is pix_in when the level is blanking, SYNC_CODE (default 10'h010) when it is sync tip, and TRI_CODE (default 10'h3C0) when it is tri-level.
- R8: The sequencer is active only when input_mode equals 5'b00001. With any other value, the level goes to blanking at the next edge, sync edges are ignored and sync_err is not set.
- R9: While the sequencer is inactive, tc_hit pulses for one cycle after the clock edge that samples the fourth word of the sequence 10'h3FF, 10'h000, 10'h000, any word. While the sequencer is active, tc_hit stays 0 and the sequence is not tracked.
- R10: ovs_en follows ovs_req and cp_en follows cp_req while the sequencer is inactive. Both enables are 0 while it is active.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| input_mode | input | 5 | Input-mode field; 5'b00001 selects the non-standard path |
| hsync_in | input | 1 | User-driven horizontal sync |
| vsync_in | input | 1 | User-driven vertical sync |
| pix_in | input | DW (10) | Pixel data word |
| ovs_req | input | 1 | Oversampling requested |
| cp_req | input | 1 | Copy-protection requested |
| pix_out | output | DW (10) | Output word: pixel or sync code |
| level_out | output | 2 | Current level: 0 blanking, 1 sync tip, 2 tri-level |
| sync_err | output | 1 | Sticky flag for an illegal sync edge combination |
| tc_hit | output | 1 | One-cycle pulse when an embedded timing code is found |
| ovs_en | output | 1 | Gated oversampling enable |
| cp_en | output | 1 | Gated copy-protection enable |

## Verification
The level machine is driven in two ways. The first is a plain two-level pattern with vsync held low, which covers R2 and R5. The second is a full tri-level cycle in which hsync and vsync fall together, which covers R2 to R4. Comparing the two patterns separates the vsync-low variant of the blanking exit from the vsync-falling variant. Lone vsync edges in blanking then exercise the error path and show that the level holds. Toggling the syncs under a non-selected mode value shows that the edges are ignored there. The timing-code preamble is fed with a repeated leading word and then fed again with the mode selected, which separates detection from suppression.

// File: rtl/tls_pkg.sv
package tls_pkg;

  typedef enum logic [1:0] {
    LVL_B = 2'd0,
    LVL_C = 2'd1,
    LVL_A = 2'd2
  } lvl_e;

  typedef struct packed {
    logic rise;
    logic fall;
    logic low;
    logic high;
  } edge_t;

  typedef struct packed {
    lvl_e nxt;
    logic bad;
  } step_t;

  function automatic logic any_edge(edge_t h, edge_t v);
    return h.rise | h.fall | v.rise | v.fall;
  endfunction

  function automatic step_t level_step(lvl_e cur, edge_t h, edge_t v);
    step_t r;
    r.nxt = cur;
    r.bad = 1'b0;
    case (cur)
      LVL_B: begin
        if (h.fall && (v.fall || v.low)) r.nxt = LVL_C;
        else if (any_edge(h, v))         r.bad = 1'b1;
      end
      LVL_C: begin
        if (v.rise && h.low)             r.nxt = LVL_A;
        else if (h.rise && v.low)        r.nxt = LVL_B;
        else if (any_edge(h, v))         r.bad = 1'b1;
      end
      LVL_A: begin
        if (h.rise && v.high)            r.nxt = LVL_B;
        else if (any_edge(h, v))         r.bad = 1'b1;
      end
      default: r.nxt = LVL_B;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/tls_edge_ch.sv
module tls_edge_ch
  import tls_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  sig_in,
  output edge_t ev
);
  logic cur_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q  <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      cur_q  <= sig_in;
      prev_q <= cur_q;
    end
  end

  always_comb begin
    ev.rise = cur_q & ~prev_q;
    ev.fall = ~cur_q & prev_q;
    ev.low  = ~cur_q & ~prev_q;
    ev.high = cur_q & prev_q;
  end
endmodule

// File: rtl/tls_level_fsm.sv
module tls_level_fsm
  import tls_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  active,
  input  edge_t h_ev,
  input  edge_t v_ev,
  output lvl_e  level,
  output logic  bad_evt,
  output logic  err
);
  step_t st;

  always_comb begin
    st      = level_step(level, h_ev, v_ev);
    bad_evt = active & st.bad;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level <= LVL_B;
      err   <= 1'b0;
    end else begin
      level <= active ? st.nxt : LVL_B;
      if (bad_evt) err <= 1'b1;
    end
  end
endmodule

// File: rtl/tls_word_mux.sv
module tls_word_mux
  import tls_pkg::*;
#(
  parameter int DW = 10,
  parameter logic [DW-1:0] SYNC_CODE = 10'h010,
  parameter logic [DW-1:0] TRI_CODE  = 10'h3C0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  lvl_e          level,
  input  logic [DW-1:0] pix_in,
  output logic [DW-1:0] pix_out
);
  function automatic logic [DW-1:0] pick_word(lvl_e l, logic [DW-1:0] p);
    case (l)
      LVL_C:   return SYNC_CODE;
      LVL_A:   return TRI_CODE;
      default: return p;
    endcase
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pix_out <= '0;
    else        pix_out <= pick_word(level, pix_in);
  end
endmodule

// File: rtl/tls_code_det.sv
module tls_code_det #(
  parameter int DW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [DW-1:0] word,
  output logic          hit
);
  localparam logic [DW-1:0] W_MAX = '1;
  localparam logic [DW-1:0] W_MIN = '0;

  logic [1:0] cnt;

  function automatic logic [1:0] restart(logic [DW-1:0] w);
    return (w == W_MAX) ? 2'd1 : 2'd0;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= 2'd0;
      hit <= 1'b0;
    end else if (!en) begin
      cnt <= 2'd0;
      hit <= 1'b0;
    end else begin
      hit <= (cnt == 2'd3);
      case (cnt)
        2'd0:    cnt <= restart(word);
        2'd1:    cnt <= (word == W_MIN) ? 2'd2 : restart(word);
        2'd2:    cnt <= (word == W_MIN) ? 2'd3 : restart(word);
        default: cnt <= restart(word);
      endcase
    end
  end
endmodule

// File: rtl/trilevel_seq.sv
module trilevel_seq
  import tls_pkg::*;
#(
  parameter int DW = 10,
  parameter int MODE_W = 5,
  parameter logic [MODE_W-1:0] MODE_NONSTD = 5'b00001,
  parameter logic [DW-1:0] SYNC_CODE = 10'h010,
  parameter logic [DW-1:0] TRI_CODE  = 10'h3C0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MODE_W-1:0] input_mode,
  input  logic              hsync_in,
  input  logic              vsync_in,
  input  logic [DW-1:0]     pix_in,
  input  logic              ovs_req,
  input  logic              cp_req,
  output logic [DW-1:0]     pix_out,
  output logic [1:0]        level_out,
  output logic              sync_err,
  output logic              tc_hit,
  output logic              ovs_en,
  output logic              cp_en
);
  localparam int NCH = 2;

  logic        nonstd_w;
  logic        bad_w;
  lvl_e        level_w;
  edge_t       ev_w [NCH];
  logic [NCH-1:0] sync_vec;

  assign nonstd_w = (input_mode == MODE_NONSTD);
  assign sync_vec = {vsync_in, hsync_in};

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    tls_edge_ch u_edge (
      .clk   (clk),
      .rst_n (rst_n),
      .sig_in(sync_vec[g]),
      .ev    (ev_w[g])
    );
  end

  tls_level_fsm u_fsm (
    .clk    (clk),
    .rst_n  (rst_n),
    .active (nonstd_w),
    .h_ev   (ev_w[0]),
    .v_ev   (ev_w[1]),
    .level  (level_w),
    .bad_evt(bad_w),
    .err    (sync_err)
  );

  tls_word_mux #(.DW(DW), .SYNC_CODE(SYNC_CODE), .TRI_CODE(TRI_CODE)) u_mux (
    .clk    (clk),
    .rst_n  (rst_n),
    .level  (level_w),
    .pix_in (pix_in),
    .pix_out(pix_out)
  );

  tls_code_det #(.DW(DW)) u_det (
    .clk  (clk),
    .rst_n(rst_n),
    .en   (~nonstd_w),
    .word (pix_in),
    .hit  (tc_hit)
  );

  assign level_out = level_w;
  assign ovs_en    = ovs_req & ~nonstd_w;
  assign cp_en     = cp_req & ~nonstd_w;
endmodule

// File: rtl/tls_chk.sv
module tls_chk
  import tls_pkg::*;
#(
  parameter int DW = 10,
  parameter logic [DW-1:0] SYNC_CODE = 10'h010,
  parameter logic [DW-1:0] TRI_CODE  = 10'h3C0
) (
  input logic          clk,
  input logic          rst_n,
  input logic          nonstd_w,
  input logic          bad_w,
  input edge_t         h_ev,
  input edge_t         v_ev,
  input logic [1:0]    level_out,
  input logic [DW-1:0] pix_out,
  input logic          sync_err,
  input logic          tc_hit
);
  // R2
  b_to_c_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (nonstd_w && level_out == 2'd0 && h_ev.fall && (v_ev.fall || v_ev.low)) |=> level_out == 2'd1);
  // R3
  c_to_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (nonstd_w && level_out == 2'd1 && v_ev.rise && h_ev.low) |=> level_out == 2'd2);
  // R4
  a_to_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (nonstd_w && level_out == 2'd2 && h_ev.rise && v_ev.high) |=> level_out == 2'd0);
  // R5
  c_to_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (nonstd_w && level_out == 2'd1 && h_ev.rise && v_ev.low) |=> level_out == 2'd0);
  // R6
  bad_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bad_w |=> ($stable(level_out) && sync_err));
  // R6
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync_err |=> sync_err);
  // R7
  sync_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    level_out == 2'd1 |=> pix_out == SYNC_CODE);
  // R7
  tri_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    level_out == 2'd2 |=> pix_out == TRI_CODE);
  // R8
  idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !nonstd_w |=> level_out == 2'd0);
  // R9
  no_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nonstd_w |=> !tc_hit);
endmodule

bind trilevel_seq tls_chk #(.DW(DW), .SYNC_CODE(SYNC_CODE), .TRI_CODE(TRI_CODE)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .nonstd_w (nonstd_w),
  .bad_w    (bad_w),
  .h_ev     (ev_w[0]),
  .v_ev     (ev_w[1]),
  .level_out(level_out),
  .pix_out  (pix_out),
  .sync_err (sync_err),
  .tc_hit   (tc_hit)
);

// File: tb/test_trilevel_seq.sv
`timescale 1ns/1ps
module test_trilevel_seq;
  localparam int DW = 10;
  localparam int SYNC_V = 16;
  localparam int TRI_V  = 960;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [4:0]    input_mode = 5'd0;
  logic          hs = 1'b0, vs = 1'b0;
  logic [DW-1:0] pix = '0;
  logic          ovs_req = 1'b0, cp_req = 1'b0;
  logic [DW-1:0] pix_out;
  logic [1:0]    level_out;
  logic          sync_err, tc_hit, ovs_en, cp_en;

  int total = 0, bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  trilevel_seq i_trilevel_seq (
    .clk(clk), .rst_n(rst_n), .input_mode(input_mode),
    .hsync_in(hs), .vsync_in(vs), .pix_in(pix),
    .ovs_req(ovs_req), .cp_req(cp_req),
    .pix_out(pix_out), .level_out(level_out), .sync_err(sync_err),
    .tc_hit(tc_hit), .ovs_en(ovs_en), .cp_en(cp_en)
  );

  // behavioural reference model
  int m_hc, m_hp, m_vc, m_vp, m_lvl, m_err, m_pix, m_tc;
  int hist[$];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_hc = 0; m_hp = 0; m_vc = 0; m_vp = 0;
      m_lvl = 0; m_err = 0; m_pix = 0; m_tc = 0;
      hist.delete();
    end else begin
      int nl;
      bit act, edge_seen;
      act = (input_mode == 5'd1);
      m_pix = (m_lvl == 1) ? SYNC_V : (m_lvl == 2) ? TRI_V : int'(pix);
      nl = m_lvl;
      edge_seen = (m_hc != m_hp) || (m_vc != m_vp);
      if (!act) nl = 0;
      else if (m_lvl == 0 && m_hp == 1 && m_hc == 0 && m_vc == 0) nl = 1;
      else if (m_lvl == 1 && m_vp == 0 && m_vc == 1 && m_hp == 0 && m_hc == 0) nl = 2;
      else if (m_lvl == 1 && m_hp == 0 && m_hc == 1 && m_vp == 0 && m_vc == 0) nl = 0;
      else if (m_lvl == 2 && m_hp == 0 && m_hc == 1 && m_vp == 1 && m_vc == 1) nl = 0;
      else if (edge_seen) m_err = 1;
      m_lvl = nl;
      if (act) begin
        m_tc = 0;
        hist.delete();
      end else begin
        m_tc = (hist.size() == 3 && hist[0] == 1023 && hist[1] == 0 && hist[2] == 0) ? 1 : 0;
        hist.push_back(int'(pix));
        if (hist.size() > 3) void'(hist.pop_front());
      end
      m_hp = m_hc; m_hc = int'(hs);
      m_vp = m_vc; m_vc = int'(vs);
    end
  end

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R2/R3/R4/R5/R6 level vs model", int'(level_out), m_lvl);
      chk("R7 pix_out vs model", int'(pix_out), m_pix);
      chk("R6 sync_err vs model", int'(sync_err), m_err);
      chk("R9 tc_hit vs model", int'(tc_hit), m_tc);
      chk("R10 ovs_en", int'(ovs_en), (ovs_req && input_mode != 5'd1) ? 1 : 0);
      chk("R10 cp_en", int'(cp_en), (cp_req && input_mode != 5'd1) ? 1 : 0);
    end
  end

  task automatic drive(bit h, bit v, int hold);
    @(negedge clk);
    hs = h; vs = v;
    repeat (hold) @(negedge clk);
  endtask

  task automatic feed(logic [DW-1:0] w);
    @(negedge clk);
    pix = w;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk("R1 level", int'(level_out), 0);
    chk("R1 pix_out", int'(pix_out), 0);
    chk("R1 sync_err", int'(sync_err), 0);
    chk("R1 tc_hit", int'(tc_hit), 0);

    pix = 10'h155;
    ovs_req = 1'b1; cp_req = 1'b1;
    // R8 hsync idles high while the path is off: no error
    drive(1, 0, 4);
    chk("R8 no error while off", int'(sync_err), 0);
    input_mode = 5'd1;
    repeat (3) @(negedge clk);
    chk("R10 ovs forced off", int'(ovs_en), 0);
    chk("R10 cp forced off", int'(cp_en), 0);

    // R2 with vsync held low, then R5
    drive(0, 0, 3);
    chk("R2 level sync tip", int'(level_out), 1);
    chk("R7 sync code", int'(pix_out), SYNC_V);
    drive(1, 0, 3);
    chk("R5 level blanking", int'(level_out), 0);
    chk("R7 pixel passthrough", int'(pix_out), 10'h155);

    // full tri-level cycle: R2, R3, R4, then R2 with falling vsync
    drive(0, 0, 3);
    chk("R2 level sync tip again", int'(level_out), 1);
    drive(0, 1, 3);
    chk("R3 level tri", int'(level_out), 2);
    chk("R7 tri code", int'(pix_out), TRI_V);
    drive(1, 1, 3);
    chk("R4 level blanking", int'(level_out), 0);
    drive(0, 0, 3);
    chk("R2 both falling to sync tip", int'(level_out), 1);
    drive(1, 0, 3);
    chk("R5 back to blanking", int'(level_out), 0);
    chk("R6 no error so far", int'(sync_err), 0);

    // R6 lone vsync edges in blanking are illegal
    drive(1, 1, 3);
    chk("R6 level held", int'(level_out), 0);
    chk("R6 error set", int'(sync_err), 1);
    drive(1, 0, 3);
    drive(0, 0, 3);
    chk("R6 legal move after error", int'(level_out), 1);
    chk("R6 error sticky", int'(sync_err), 1);
    drive(1, 0, 3);

    do_reset();
    chk("R1 error cleared", int'(sync_err), 0);

    // R8 other mode value: edges ignored
    input_mode = 5'b00011;
    drive(0, 0, 3);
    chk("R8 level held blanking", int'(level_out), 0);
    drive(0, 1, 3);
    chk("R8 no error", int'(sync_err), 0);
    drive(1, 0, 3);
    chk("R10 ovs follows", int'(ovs_en), 1);

    // R9 timing code detection when inactive, leading word repeated
    feed(10'h3FF); feed(10'h3FF); feed(10'h000); feed(10'h000); feed(10'h2AC);
    @(negedge clk);
    chk("R9 code hit", int'(tc_hit), 1);
    @(negedge clk);
    chk("R9 single pulse", int'(tc_hit), 0);

    // R9 suppressed while active
    input_mode = 5'd1;
    feed(10'h3FF); feed(10'h000); feed(10'h000); feed(10'h2AC);
    @(negedge clk);
    chk("R9 no hit while active", int'(tc_hit), 0);
    repeat (3) @(negedge clk);
    chk("R7 passthrough last word", int'(pix_out), 10'h2AC);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule